// File: doc/BRIEF.md
# Byte-Serial Stack Pointer Sequencer

This block keeps a 16-bit stack pointer and turns requests to save or restore a 16-bit register pair into two single-byte cycles on a synchronous 8-bit memory port. The stack grows downward. The pointer always addresses the most recently written byte. A save lowers the pointer before each write and stores the upper byte first. A restore reads the lower byte at the pointer first and raises the pointer after each read. Because of this, pairs come back in reverse order of saving.

A controlling unit first loads the pointer with the bottom-of-stack address. It then issues save and restore requests. The block shows that it is occupied from the cycle after it accepts a request until its final cycle. It marks the end with a single-cycle completion pulse. Requests that arrive while the block is occupied are dropped. The memory port is registered on the memory side: a read issued in one cycle returns its byte in the next cycle.

Top module: `stack_seq`

## Requirements
- R1: While reset is asserted, and after it is released, the pointer reads 0x0000, `busy` and `done` are 0, and neither `mem_we` nor `mem_re` is asserted.
- R2: `load_en` sampled while idle sets the pointer to `load_addr` at that edge, without any memory cycle.
- R3: A save accepted with pointer S writes `push_pair[15:8]` to address S-1 in the first cycle after acceptance. It writes `push_pair[7:0]` to S-2 in the second cycle. The pointer ends at S-2.
- R4: A restore accepted with pointer S reads address S in the first cycle after acceptance and S+1 in the second cycle. The pointer ends at S+2. When `done` pulses, `pop_pair` holds {byte at S+1, byte at S}.
- R5: A sequence of restores returns the saved pairs in the reverse of their save order.
- R6: `busy` is 1 for two cycles after a save is accepted and for three cycles after a restore is accepted. `done` is 1 in the cycle after that, for exactly one cycle.
- R7: Load, save and restore requests that arrive while `busy` is 1 leave the pointer, the memory and the data being written unchanged.
- R8: Pointer arithmetic wraps modulo 2^16. No overflow or underflow indication is given.
- R9: A restore never writes memory. The bytes it read stay in memory. The bottom address loaded with R2 is never written by the saves that follow.
- R10: When requests meet while idle, load wins over save, and save wins over restore.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Load pointer request |
| load_addr | input | 16 | Value for pointer load |
| push_req | input | 1 | Save pair request |
| push_pair | input | 16 | Pair to save |
| pop_req | input | 1 | Restore pair request |
| pop_pair | output | 16 | Restored pair, valid from `done` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| sp | output | 16 | Current stack pointer |
| mem_addr | output | 16 | Memory byte address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, one cycle after `mem_re` |

## Verification
Saves and restores are run from four bottom addresses: a mid-range value, 0x0001, 0x0000 and 0x8000. The values 0x0001 and 0x0000 make the pointer cross the 0xFFFF/0x0000 boundary in the middle of a pair and at its start, which separates modular arithmetic from saturating or sign-confused arithmetic. Each sweep uses pairs whose upper and lower bytes differ, so a swapped byte order or an off-by-one address shows up as a data mismatch. Stacking five pairs per sweep before unwinding tells true LIFO order apart from a pointer that only happens to return the last pair. Separate cases combine requests in one idle cycle to fix the priority, and fire all three requests in the middle of a save to show they are dropped.

// File: rtl/stack_pkg.sv
package stack_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_HI,
    ST_PUSH_LO,
    ST_POP_LO,
    ST_POP_HI,
    ST_POP_CAP
  } seq_state_t;
endpackage

// File: rtl/stack_ptr.sv
module stack_ptr #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW-1:0] ld_val,
  input  logic          dec,
  input  logic          inc,
  output logic [AW-1:0] sp
);
  logic [AW-1:0] sp_q, sp_d;
  logic          sp_en;

  assign sp_en = ld | dec | inc;

  always_comb begin
    sp_d = sp_q;
    if (ld)       sp_d = ld_val;
    else if (dec) sp_d = sp_q - AW'(1);
    else if (inc) sp_d = sp_q + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= '0;
    else if (sp_en) sp_q <= sp_d;
  end

  assign sp = sp_q;

  p_one_op_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ld, dec, inc}) <= 1);
  p_dec_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dec |=> sp == AW'($past(sp) - AW'(1)));
  p_inc_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> sp == AW'($past(sp) + AW'(1)));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld || dec || inc) |=> $stable(sp));
endmodule

// File: rtl/stack_fsm.sv
module stack_fsm
  import stack_pkg::*;
#(
  parameter int DW = 8,
  localparam int PW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic [PW-1:0] push_pair,
  input  logic [DW-1:0] mem_rdata,
  output logic          ld,
  output logic          dec,
  output logic          inc,
  output logic          mem_we,
  output logic          mem_re,
  output logic [DW-1:0] mem_wdata,
  output logic [PW-1:0] pop_pair,
  output logic          busy,
  output logic          done
);
  seq_state_t    state_q, state_d;
  logic [PW-1:0] pair_q, pair_d;
  logic          pair_en;
  logic          done_d, done_q;
  logic          idle;

  assign idle = (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    pair_d  = pair_q;
    pair_en = 1'b0;
    done_d  = 1'b0;
    ld      = 1'b0;
    dec     = 1'b0;
    inc     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (load_en) begin
          ld = 1'b1;
        end else if (push_req) begin
          dec     = 1'b1;
          pair_d  = push_pair;
          pair_en = 1'b1;
          state_d = ST_PUSH_HI;
        end else if (pop_req) begin
          state_d = ST_POP_LO;
        end
      end
      ST_PUSH_HI: begin
        dec     = 1'b1;
        state_d = ST_PUSH_LO;
      end
      ST_PUSH_LO: begin
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      ST_POP_LO: begin
        inc     = 1'b1;
        state_d = ST_POP_HI;
      end
      ST_POP_HI: begin
        inc     = 1'b1;
        pair_d  = {pair_q[PW-1:DW], mem_rdata};
        pair_en = 1'b1;
        state_d = ST_POP_CAP;
      end
      ST_POP_CAP: begin
        pair_d  = {mem_rdata, pair_q[DW-1:0]};
        pair_en = 1'b1;
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pair_q <= '0;
    else if (pair_en) pair_q <= pair_d;
  end

  assign mem_we    = (state_q == ST_PUSH_HI) || (state_q == ST_PUSH_LO);
  assign mem_re    = (state_q == ST_POP_LO) || (state_q == ST_POP_HI);
  assign mem_wdata = (state_q == ST_PUSH_HI) ? pair_q[PW-1:DW] : pair_q[DW-1:0];
  assign pop_pair  = pair_q;
  assign busy      = !idle;
  assign done      = done_q;

  p_push_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PUSH_HI) |=> (state_q == ST_PUSH_LO) && mem_we);
  p_pop_nowrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_POP_LO) |=> mem_re && !mem_we);
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ld);
endmodule

// File: rtl/stack_seq.sv
module stack_seq #(
  parameter int AW = 16,
  parameter int DW = 8,
  localparam int PW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [AW-1:0] load_addr,
  input  logic          push_req,
  input  logic [PW-1:0] push_pair,
  input  logic          pop_req,
  output logic [PW-1:0] pop_pair,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] sp,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic          mem_re,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       ld, dec, inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  stack_fsm #(.DW(DW)) i_fsm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load_en   (load_en),
    .push_req  (push_req),
    .pop_req   (pop_req),
    .push_pair (push_pair),
    .mem_rdata (mem_rdata),
    .ld        (ld),
    .dec       (dec),
    .inc       (inc),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_wdata (mem_wdata),
    .pop_pair  (pop_pair),
    .busy      (busy),
    .done      (done)
  );

  stack_ptr #(.AW(AW)) i_ptr (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .ld     (ld),
    .ld_val (load_addr),
    .dec    (dec),
    .inc    (inc),
    .sp     (sp)
  );

  assign mem_addr = sp;

  p_no_access_reset_r1: assert property (@(posedge clk)
    !rst_int_n |-> !mem_we && !mem_re);
endmodule

// File: tb/test_stack_seq.sv
module test_stack_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        load_en, push_req, pop_req;
  logic [15:0] load_addr, push_pair, pop_pair, sp, mem_addr;
  logic        busy, done, mem_we, mem_re;
  logic [7:0]  mem_wdata, mem_rdata;

  logic [7:0]  mem [65536];
  int          n_tests = 0, n_fail = 0;
  logic [15:0] sp_m;
  logic [15:0] watch_addr;
  bit          watch_on = 1'b0;
  int          bottom_hits = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  stack_seq i_stack_seq (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
    .push_req(push_req), .push_pair(push_pair), .pop_req(pop_req),
    .pop_pair(pop_pair), .busy(busy), .done(done), .sp(sp),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr];
  end

  always @(negedge clk)
    if (watch_on && mem_we && mem_addr == watch_addr) bottom_hits++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [15:0] a);
    @(negedge clk); load_en = 1'b1; load_addr = a;
    @(negedge clk); load_en = 1'b0;
    chk(sp == a, "R2 load value", sp, a);
    chk(!busy && !mem_we && !mem_re, "R2 no cycle", {busy, mem_we, mem_re}, 0);
    sp_m = a;
  endtask

  task automatic do_push(input logic [15:0] pr, input bit disturb);
    logic [15:0] s0 = sp_m;
    @(negedge clk); push_req = 1'b1; push_pair = pr;
    @(negedge clk); push_req = 1'b0;
    chk(busy, "R6 busy push 1", busy, 1);
    chk(mem_we && mem_addr == 16'(s0 - 16'd1) && mem_wdata == pr[15:8],
        "R3 high byte first", {mem_we, mem_addr, mem_wdata}, {1'b1, 16'(s0 - 16'd1), pr[15:8]});
    if (disturb) begin
      push_req = 1'b1; pop_req = 1'b1; load_en = 1'b1;
      load_addr = 16'h1234; push_pair = ~pr;
    end
    @(negedge clk);
    push_req = 1'b0; pop_req = 1'b0; load_en = 1'b0;
    chk(busy, "R6 busy push 2", busy, 1);
    chk(mem_we && mem_addr == 16'(s0 - 16'd2) && mem_wdata == pr[7:0],
        "R3 low byte second (R7 when disturbed)", {mem_we, mem_addr, mem_wdata},
        {1'b1, 16'(s0 - 16'd2), pr[7:0]});
    @(negedge clk);
    chk(done && !busy, "R6 done after push", {done, busy}, 2'b10);
    chk(sp == 16'(s0 - 16'd2), "R3 pointer after push (R7 when disturbed)", sp, 16'(s0 - 16'd2));
    @(negedge clk);
    chk(!done && !busy && !mem_we, "R6 done single / R7 no extra", {done, busy, mem_we}, 0);
    sp_m = 16'(s0 - 16'd2);
  endtask

  task automatic do_pop(input logic [15:0] exp);
    logic [15:0] s0 = sp_m;
    @(negedge clk); pop_req = 1'b1;
    @(negedge clk); pop_req = 1'b0;
    chk(mem_re && !mem_we && mem_addr == s0, "R4 read low addr", {mem_re, mem_we, mem_addr}, {2'b10, s0});
    @(negedge clk);
    chk(mem_re && !mem_we && mem_addr == 16'(s0 + 16'd1), "R4 read high addr",
        {mem_re, mem_we, mem_addr}, {2'b10, 16'(s0 + 16'd1)});
    @(negedge clk);
    chk(busy && !done && !mem_we, "R6 busy pop 3 / R9", {busy, done, mem_we}, 3'b100);
    @(negedge clk);
    chk(done && !busy, "R6 done after pop", {done, busy}, 2'b10);
    chk(pop_pair == exp, "R4 R5 popped pair", pop_pair, exp);
    chk(sp == 16'(s0 + 16'd2), "R4 pointer after pop", sp, 16'(s0 + 16'd2));
    @(negedge clk);
    chk(!done, "R6 done single pop", done, 0);
    sp_m = 16'(s0 + 16'd2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] bottoms [4];
    logic [15:0] pairs [5];
    bottoms[0] = 16'h2700; bottoms[1] = 16'h0001;
    bottoms[2] = 16'h0000; bottoms[3] = 16'h8000;
    rst_n = 1'b0; load_en = 1'b0; push_req = 1'b0; pop_req = 1'b0;
    load_addr = '0; push_pair = '0;
    repeat (3) @(negedge clk);
    chk(sp == 16'h0 && !busy && !done && !mem_we && !mem_re, "R1 in reset",
        {sp, busy, done, mem_we, mem_re}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(sp == 16'h0 && !busy && !done && !mem_we && !mem_re, "R1 after reset",
        {sp, busy, done, mem_we, mem_re}, 0);
    sp_m = 16'h0;

    for (int b = 0; b < 4; b++) begin
      do_load(bottoms[b]);
      watch_addr = bottoms[b]; watch_on = 1'b1;
      for (int i = 0; i < 5; i++) begin
        pairs[i] = 16'(bottoms[b] * 3 + i * 16'h1357 + 16'h0F1E);
        do_push(pairs[i], (b == 0 && i == 2));
      end
      watch_on = 1'b0;
      for (int i = 0; i < 5; i++) begin
        chk(mem[16'(bottoms[b] - 16'(2 * i) - 16'd1)] == pairs[i][15:8], "R3 R8 mem high",
            mem[16'(bottoms[b] - 16'(2 * i) - 16'd1)], pairs[i][15:8]);
        chk(mem[16'(bottoms[b] - 16'(2 * i) - 16'd2)] == pairs[i][7:0], "R3 R8 mem low",
            mem[16'(bottoms[b] - 16'(2 * i) - 16'd2)], pairs[i][7:0]);
      end
      chk(bottom_hits == 0, "R9 bottom untouched", bottom_hits, 0);
      for (int i = 4; i >= 0; i--) do_pop(pairs[i]);
      chk(sp == bottoms[b], "R5 R8 pointer back at bottom", sp, bottoms[b]);
      chk(mem[16'(bottoms[b] - 16'd10)] == pairs[4][7:0], "R9 stale byte kept",
          mem[16'(bottoms[b] - 16'd10)], pairs[4][7:0]);
    end

    // R10: load beats save and restore
    do_load(16'h4000);
    @(negedge clk); load_en = 1'b1; load_addr = 16'h5000; push_req = 1'b1; pop_req = 1'b1;
    push_pair = 16'hBEEF;
    @(negedge clk); load_en = 1'b0; push_req = 1'b0; pop_req = 1'b0;
    chk(sp == 16'h5000 && !busy && !mem_we, "R10 load wins", {sp, busy, mem_we}, {16'h5000, 2'b00});
    sp_m = 16'h5000;
    // R10: save beats restore
    @(negedge clk); push_req = 1'b1; pop_req = 1'b1; push_pair = 16'hBEEF;
    @(negedge clk); push_req = 1'b0; pop_req = 1'b0;
    chk(mem_we && !mem_re && mem_addr == 16'h4FFF && mem_wdata == 8'hBE, "R10 save wins",
        {mem_we, mem_re, mem_addr, mem_wdata}, {2'b10, 16'h4FFF, 8'hBE});
    repeat (3) @(negedge clk);
    sp_m = 16'h4FFE;
    do_pop(16'hBEEF);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule